// File: doc/BRIEF.md
# Thermometer-to-Binary Encoder (Recursive Multiplexer Tree)

This block turns the thermometer word of a flash comparator bank into a straight binary count. A parameter N sets the output width, and the input is 2^N-1 taps wide. The input must be free of bubbles: every tap below the signal level is 1 and every tap at or above it is 0. The default is N=8, which takes a 255-tap input and gives an 8-bit result.

The encoder resolves one bit per tree level, starting with the most significant bit:

- The tap at the centre of the current sub-word gives that level's bit directly.
- That bit then drives a rank of two-input multiplexers. With the bit at 1, each multiplexer passes a tap from the upper half. With the bit at 0, it passes the matching tap from the lower half.
- The half that was passed on is itself a thermometer word, one bit narrower in resolution. The next level works on it the same way.
- The last level has a single tap left, which is the LSB.

Every multiplexer passes its D1 input when its select is 1 and its D2 input when its select is 0.

A parameter PIPE chooses the timing:

- PIPE=1 puts a register after every level, so each stage has the depth of one multiplexer.
- PIPE=0 keeps the whole tree combinational and registers only the result.

A valid flag travels alongside the data through the same registers. Reset is synchronous.

Top module: `thermo_bin_encoder`

## Requirements
- R1: For a bubble-free input with taps 0..L-1 set and the rest clear, bin_out equals L once the word reaches the output.
- R2: The most significant output bit equals tap index 2^(N-1)-1 of the input word.
- R3: The bit below the MSB equals tap 2^(N-2)-1 when the MSB is 0 and tap 3*2^(N-2)-1 when the MSB is 1. Each lower level repeats this on the half that the bits above it selected.
- R4: An all-zeros input encodes to 0, and an all-ones input encodes to 2^N-1.
- R5: With PIPE=1, a word presented with in_valid appears on bin_out exactly N clock cycles later. out_valid equals in_valid delayed by the same N cycles. A new word is accepted every cycle.
- R6: With PIPE=0, the result and out_valid appear one clock cycle after the input, for any N in the range 2 to 8 (exercised with N=4).
- R7: A clock edge with rst high clears out_valid and bin_out to 0 on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| therm_in | input | 2^N-1 | Thermometer word, tap 0 is the lowest level |
| in_valid | input | 1 | Marks therm_in as carrying a sample |
| bin_out | output | N | Binary level of the word presented the latency earlier |
| out_valid | output | 1 | in_valid delayed by the latency |

## Verification
A full sweep drives every level from 0 to 255 into the pipelined N=8 instance, so each tap is once the boundary. This separates a wrong midpoint tap (R2) from a wrong half selection at a lower level (R3). The two end codes, all zeros and all ones, are also driven back to back, which exposes a multiplexer whose D1 and D2 inputs are swapped.

Random levels with a random valid pattern show whether the data and the flag stay aligned at N cycles of latency. A reset in mid-stream with the pipeline full checks that every in-flight word is cleared. A second instance, combinational with N=4, runs the same kinds of stimulus to show that the one-cycle latency and the narrow width hold.

// File: rtl/thermo_enc_pkg.sv
package thermo_enc_pkg;

    localparam int MIN_N = 2;
    localparam int MAX_N = 8;

    // width of the thermometer sub-word handled by tree level k
    function automatic int sub_width(input int n, input int k);
        return (1 << (n - k)) - 1;
    endfunction

    // width of the sub-word handed from level k to level k+1 (at least 1)
    function automatic int next_width(input int n, input int k);
        int w;
        w = sub_width(n, k + 1);
        return (w < 1) ? 1 : w;
    endfunction

    // bit offset of the slot that feeds level k in the packed sub-word bus
    function automatic int slot_offset(input int n, input int k);
        int acc;
        acc = 0;
        for (int j = 0; j < k; j++) begin
            acc += sub_width(n, j);
        end
        return acc;
    endfunction

    function automatic int latency(input int n, input bit pipe);
        return pipe ? n : 1;
    endfunction

endpackage

// File: rtl/thermo_enc_mux2.sv
module thermo_enc_mux2 (
    input  logic d1,
    input  logic d2,
    input  logic sel,
    output logic y
);
    // select high passes d1, select low passes d2
    assign y = sel ? d1 : d2;
endmodule

// File: rtl/thermo_enc_level.sv
module thermo_enc_level #(
    parameter int N = 8,
    parameter int K = 0
) (
    input  logic [thermo_enc_pkg::sub_width(N, K)-1:0]  sub_i,
    input  logic [N-1:0]                                bits_i,
    output logic [thermo_enc_pkg::next_width(N, K)-1:0] sub_o,
    output logic [N-1:0]                                bits_o
);
    localparam int SW  = thermo_enc_pkg::sub_width(N, K);
    localparam int NW  = thermo_enc_pkg::next_width(N, K);
    localparam int MID = SW / 2;

    logic res_bit;

    assign res_bit = sub_i[MID];

    always_comb begin
        bits_o            = bits_i;
        bits_o[N - 1 - K] = res_bit;
    end

    if (SW > 1) begin : g_fold
        for (genvar i = 0; i < NW; i++) begin : g_mux
            thermo_enc_mux2 u_mux (
                .d1  (sub_i[MID + 1 + i]),
                .d2  (sub_i[i]),
                .sel (res_bit),
                .y   (sub_o[i])
            );
        end
    end else begin : g_leaf
        assign sub_o = '0;
    end
endmodule

// File: rtl/thermo_enc_stage.sv
module thermo_enc_stage #(
    parameter int N   = 8,
    parameter int SW  = 1,
    parameter bit REG = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] sub_i,
    input  logic [N-1:0]  bits_i,
    input  logic          vld_i,
    output logic [SW-1:0] sub_o,
    output logic [N-1:0]  bits_o,
    output logic          vld_o
);
    typedef struct packed {
        logic [SW-1:0] sub;
        logic [N-1:0]  bits;
        logic          vld;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d.sub  = sub_i;
        st_d.bits = bits_i;
        st_d.vld  = vld_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sub_o  = REG ? st_q.sub  : st_d.sub;
    assign bits_o = REG ? st_q.bits : st_d.bits;
    assign vld_o  = REG ? st_q.vld  : st_d.vld;
endmodule

// File: rtl/thermo_bin_encoder.sv
module thermo_bin_encoder #(
    parameter int N    = 8,
    parameter bit PIPE = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [(2**N)-2:0]  therm_in,
    input  logic               in_valid,
    output logic [N-1:0]       bin_out,
    output logic               out_valid
);
    import thermo_enc_pkg::*;

    localparam int TOT = slot_offset(N, N) + 1;

    logic [TOT-1:0]        sub_bus;
    logic [N:0][N-1:0]     bits_bus;
    logic [N:0]            vld_bus;
    logic                  unused_tail;

    assign sub_bus[slot_offset(N, 1)-1:0] = therm_in;
    assign bits_bus[0]                    = '0;
    assign vld_bus[0]                     = in_valid;

    for (genvar k = 0; k < N; k++) begin : g_lvl
        localparam int SW  = sub_width(N, k);
        localparam int NW  = next_width(N, k);
        localparam int OFI = slot_offset(N, k);
        localparam int OFO = slot_offset(N, k + 1);
        localparam bit REG = PIPE || (k == N - 1);

        logic [NW-1:0] sub_c;
        logic [N-1:0]  bits_c;

        thermo_enc_level #(.N(N), .K(k)) u_level (
            .sub_i  (sub_bus[OFI +: SW]),
            .bits_i (bits_bus[k]),
            .sub_o  (sub_c),
            .bits_o (bits_c)
        );

        thermo_enc_stage #(.N(N), .SW(NW), .REG(REG)) u_stage (
            .clk    (clk),
            .rst    (rst),
            .sub_i  (sub_c),
            .bits_i (bits_c),
            .vld_i  (vld_bus[k]),
            .sub_o  (sub_bus[OFO +: NW]),
            .bits_o (bits_bus[k + 1]),
            .vld_o  (vld_bus[k + 1])
        );
    end

    assign unused_tail = sub_bus[TOT-1];
    assign bin_out     = bits_bus[N];
    assign out_valid   = vld_bus[N];
endmodule

// File: rtl/thermo_bin_encoder_chk.sv
module thermo_bin_encoder_chk #(
    parameter int N    = 8,
    parameter bit PIPE = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic [(2**N)-2:0] therm_in,
    input logic              in_valid,
    input logic [N-1:0]      bin_out,
    input logic              out_valid
);
    localparam int W   = (2**N) - 1;
    localparam int LAT = thermo_enc_pkg::latency(N, PIPE);
    localparam int MID = (1 << (N - 1)) - 1;

    logic [N-1:0] exp_q [LAT];
    logic         vld_q [LAT];
    logic         ok_q  [LAT];
    logic         msb_q [LAT];
    logic [W-1:0] therm_inc;

    assign therm_inc = therm_in + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LAT; i++) begin
                exp_q[i] <= '0;
                vld_q[i] <= 1'b0;
                ok_q[i]  <= 1'b0;
                msb_q[i] <= 1'b0;
            end
        end else begin
            exp_q[0] <= N'($countones(therm_in));
            vld_q[0] <= in_valid;
            ok_q[0]  <= ((therm_in & therm_inc) == '0);
            msb_q[0] <= therm_in[MID];
            for (int i = 1; i < LAT; i++) begin
                exp_q[i] <= exp_q[i-1];
                vld_q[i] <= vld_q[i-1];
                ok_q[i]  <= ok_q[i-1];
                msb_q[i] <= msb_q[i-1];
            end
        end
    end

    p_level_value_r1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ok_q[LAT-1]) |-> (bin_out == exp_q[LAT-1]));

    p_msb_tap_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (bin_out[N-1] == msb_q[LAT-1]));

    // R5 and R6: flag latency matches the configured pipeline depth
    p_valid_latency_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid == vld_q[LAT-1]);

    p_reset_clear_r7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && bin_out == '0));
endmodule

bind thermo_bin_encoder thermo_bin_encoder_chk #(.N(N), .PIPE(PIPE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .therm_in  (therm_in),
    .in_valid  (in_valid),
    .bin_out   (bin_out),
    .out_valid (out_valid)
);

// File: tb/thermo_bin_encoder_tb.sv
module thermo_bin_encoder_tb;
    localparam int N  = 8;
    localparam int W  = 255;
    localparam int NF = 4;
    localparam int WF = 15;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst;
    logic [W-1:0]  t;
    logic          v;
    logic [N-1:0]  b;
    logic          ov;
    logic [WF-1:0] tf;
    logic          vf;
    logic [NF-1:0] bf;
    logic          ovf;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    int hv  [16];
    bit hvl [16];
    int fv;
    bit fvl;
    bit done = 1'b0;

    thermo_bin_encoder #(.N(N), .PIPE(1'b1)) u_dut (
        .clk(clk), .rst(rst), .therm_in(t), .in_valid(v),
        .bin_out(b), .out_valid(ov)
    );

    thermo_bin_encoder #(.N(NF), .PIPE(1'b0)) u_dut_flat (
        .clk(clk), .rst(rst), .therm_in(tf), .in_valid(vf),
        .bin_out(bf), .out_valid(ovf)
    );

    function automatic logic [W-1:0] therm8(input int lvl);
        logic [W-1:0] r;
        r = '0;
        for (int i = 0; i < W; i++) if (i < lvl) r[i] = 1'b1;
        return r;
    endfunction

    function automatic logic [WF-1:0] therm4(input int lvl);
        logic [WF-1:0] r;
        r = '0;
        for (int i = 0; i < WF; i++) if (i < lvl) r[i] = 1'b1;
        return r;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // called at a falling edge: check outputs, then drive the next sample
    task automatic step(input int lvl, input bit vl, input int lvlf, input bit vlf);
        int idx;
        int e;
        idx = (cyc - N + 16) % 16;
        e   = hv[idx];
        chk("R5 valid", int'(ov), int'(hvl[idx]));
        chk("R1 value", int'(b), e);
        chk("R2 msb", int'(b[7]), (e >= 128) ? 1 : 0);
        chk("R3 second bit", int'(b[6]), (e >= 128) ? ((e >= 192) ? 1 : 0) : ((e >= 64) ? 1 : 0));
        if (e == 0 || e == 255) chk("R4 end code", int'(b), e);
        chk("R6 flat value", int'(bf), fv);
        chk("R6 flat valid", int'(ovf), int'(fvl));
        t  = therm8(lvl);
        v  = vl;
        tf = therm4(lvlf);
        vf = vlf;
        hv[cyc % 16]  = lvl;
        hvl[cyc % 16] = vl;
        fv  = lvlf;
        fvl = vlf;
        @(negedge clk);
        cyc++;
    endtask

    task automatic do_reset(input int len);
        rst = 1'b1;
        t   = '0;
        v   = 1'b0;
        tf  = '0;
        vf  = 1'b0;
        for (int i = 0; i < 16; i++) begin
            hv[i]  = 0;
            hvl[i] = 1'b0;
        end
        fv  = 0;
        fvl = 1'b0;
        @(negedge clk);
        cyc++;
        chk("R7 valid cleared", int'(ov), 0);
        chk("R7 value cleared", int'(b), 0);
        chk("R7 flat cleared", int'(ovf) + int'(bf), 0);
        for (int i = 1; i < len; i++) begin
            @(negedge clk);
            cyc++;
        end
        rst = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int seed;
        rst = 1'b1;
        t   = '0;
        v   = 1'b0;
        tf  = '0;
        vf  = 1'b0;
        seed = $urandom(32'h1234_5a5a);
        @(negedge clk);
        do_reset(10);
        // R1/R2/R3: full sweep of every level
        for (int l = 0; l < 256; l++) step(l, 1'b1, l % 16, 1'b1);
        // R4: end codes back to back
        for (int i = 0; i < 8; i++) step((i % 2) ? 255 : 0, 1'b1, (i % 2) ? 15 : 0, 1'b1);
        // R5/R6: random levels with a random valid pattern
        for (int i = 0; i < 3000; i++)
            step(int'($urandom_range(0, 255)), 1'(($urandom % 3) != 0),
                 int'($urandom_range(0, 15)), 1'($urandom % 2));
        // R7: reset with the pipeline full
        for (int i = 0; i < N; i++) step(200 + i, 1'b1, 9, 1'b1);
        do_reset(1);
        for (int i = 0; i < N + 4; i++) step(255, 1'b0, 15, 1'b0);
        for (int i = 0; i < N + 4; i++) step(i * 17, 1'b1, i, 1'b1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule